// File: doc/BRIEF.md
# Timebase-Tap Interval Timer

This block keeps a free-running timebase counter and derives two periodic events from it: a fixed-interval tick and a watchdog-interval tick. Each tick watches one bit of the timebase, chosen from a period field in a 32-bit control word. A tick fires only on the clock edge where that bit changes from 0 to 1. The tick then sets a sticky flag in a 32-bit status word.

Software clears status flags by writing ones to them. Each flag drives a level interrupt output through its own enable bit in the control word. A build-time parameter selects one of two ways to pick the bit. In the standard way, the 2-bit period field indexes a four-entry parameter table. In the extended way, the period field is joined with a 4-bit extension field and the bit is counted down from the top of the timebase. A debug-resume pulse clears all watchdog state in the status word, so a long halt does not leave a stale watchdog flag behind.

Top module: `tbtap_timer_unit`

## Requirements
- R1: While reset is asserted, and on its release, the control word, the status word and the timebase all read 0, and both interrupt outputs are low.
- R2: The timebase `tb_q` rises by exactly 1 on every clock edge after reset.
- R3: A control write stores all 32 bits of `ctl_wr_data`, and `ctl_q` shows them from the next cycle.
- R4: In standard mode, control bits 25:24 pick the fixed-interval tap from `FIT_TAPS` (default bits 4, 6, 8, 10 for codes 0 to 3). Control bits 31:30 pick the watchdog tap from `WDT_TAPS` (default bits 7, 9, 11, 13).
- R5: In extended mode, the tapped bit is 63 minus the 6-bit value {extension, period}. The fixed-interval extension is in control bits 16:13 and the watchdog extension is in control bits 20:17.
- R6: A tap event happens only on an edge where the selected timebase bit goes from 0 to 1. A fixed-interval event sets status bit 26, and a watchdog event sets status bit 30. Each flag shows in the same cycle that `tb_q` first shows the tapped bit set.
- R7: Status flags stay set until cleared. A status write clears every bit that is 1 in `sts_wr_data`, one cycle later, and leaves all other bits unchanged.
- R8: If an event fires in the same cycle that software clears its flag, the flag ends up set.
- R9: A `dbg_resume` pulse clears status bits 31:28 on the next cycle and leaves bit 26 unchanged.
- R10: `fit_irq` is high exactly when status bit 26 and control bit 23 are both 1. `wdt_irq` is high exactly when status bit 30 and control bit 27 are both 1.
- R11: Changing the period field to a tap whose bit is already 1 does not fire an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word write value |
| sts_wr_en | input | 1 | Status word write strobe (write one to clear) |
| sts_wr_data | input | 32 | Status word clear mask |
| dbg_resume | input | 1 | Debug-resume pulse; clears watchdog status |
| ctl_q | output | 32 | Current control word |
| sts_q | output | 32 | Current status word |
| tb_q | output | TB_W | Timebase count |
| fit_irq | output | 1 | Fixed-interval interrupt level |
| wdt_irq | output | 1 | Watchdog interrupt level |

## Verification
Control and status writes take effect one cycle after the strobe. A tap event sets its flag on the same edge where `tb_q` first shows the tapped bit as 1, so the bench works out that cycle from the timebase alone. Interrupts follow status and control in the same cycle. Every expected value is queued with the exact cycle number in which it is due, and a monitor compares it away from the clock edge in that cycle. Each event is checked one cycle early (still clear) and in its due cycle (set), so a result that arrives a cycle off is caught.

// File: rtl/tbtap_pkg.sv
package tbtap_pkg;
   typedef logic [31:0] word_t;

   // control word field positions
   localparam int unsigned CB_WD_PER_LSB = 30;
   localparam int unsigned CB_WD_RST_LSB = 28;
   localparam int unsigned CB_WD_IE      = 27;
   localparam int unsigned CB_DEC_IE     = 26;
   localparam int unsigned CB_FI_PER_LSB = 24;
   localparam int unsigned CB_FI_IE      = 23;
   localparam int unsigned CB_AUTO_RLD   = 22;
   localparam int unsigned CB_WD_EXT_LSB = 17;
   localparam int unsigned CB_FI_EXT_LSB = 13;

   // status word field positions
   localparam int unsigned SB_WD_ARM     = 31;
   localparam int unsigned SB_WD_ST      = 30;
   localparam int unsigned SB_WD_RST_LSB = 28;
   localparam int unsigned SB_DEC_ST     = 27;
   localparam int unsigned SB_FI_ST      = 26;

   localparam word_t RESUME_MASK = (word_t'(1) << SB_WD_ARM)
                                 | (word_t'(1) << SB_WD_ST)
                                 | (word_t'(3) << SB_WD_RST_LSB);
endpackage

// File: rtl/tbtap_timebase.sv
module tbtap_timebase #(
   parameter int unsigned TB_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TB_W-1:0] tb_q,
   output logic [TB_W-1:0] tb_nxt
);
   if (TB_W < 8) begin : g_bad_width
      $error("tbtap_timebase: TB_W must be at least 8");
   end

   assign tb_nxt = tb_q + TB_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tb_q <= '0;
      else        tb_q <= tb_nxt;
   end
endmodule

// File: rtl/tbtap_tap.sv
module tbtap_tap #(
   parameter int unsigned         TB_W     = 64,
   parameter int unsigned         TAP_W    = 6,
   parameter bit                  EXT_MODE = 1'b0,
   parameter logic [4*TAP_W-1:0]  TAPS     = '0
) (
   input  logic [1:0]      per_fld,
   input  logic [3:0]      ext_fld,
   input  logic [TB_W-1:0] tb_q,
   input  logic [TB_W-1:0] tb_nxt,
   output logic            evt
);
   logic [TAP_W-1:0] sel;

   if (TAP_W != $clog2(TB_W)) begin : g_bad_tap_w
      $error("tbtap_tap: TAP_W must equal clog2(TB_W)");
   end

   if (EXT_MODE) begin : g_ext
      if (TB_W != 64) begin : g_bad_ext
         $error("tbtap_tap: extended selection needs a 64-bit timebase");
      end
      // {ext,per} equals per | (ext << 2): the fields do not overlap
      assign sel = TAP_W'(TB_W - 1) - TAP_W'({ext_fld, per_fld});
   end else begin : g_std
      for (genvar gi = 0; gi < 4; gi++) begin : g_chk
         if (TAPS[gi*TAP_W +: TAP_W] >= TB_W) begin : g_bad_tap
            $error("tbtap_tap: tap table entry outside the timebase");
         end
      end
      logic unused_ext;
      assign unused_ext = ^ext_fld;
      assign sel = TAPS[32'(per_fld)*TAP_W +: TAP_W];
   end

   // rising transition of the tapped bit on the coming edge
   assign evt = ~tb_q[sel] & tb_nxt[sel];
endmodule

// File: rtl/tbtap_regs.sv
module tbtap_regs
   import tbtap_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ctl_wr_en,
   input  word_t ctl_wr_data,
   input  logic  sts_wr_en,
   input  word_t sts_wr_data,
   input  logic  dbg_resume,
   input  logic  fit_evt,
   input  logic  wdt_evt,
   output word_t ctl_q,
   output word_t sts_q
);
   word_t sts_clr, sts_set, sts_d;

   always_comb begin
      sts_clr = sts_wr_en ? sts_wr_data : '0;
      if (dbg_resume) sts_clr = sts_clr | RESUME_MASK;
      sts_set = (word_t'(fit_evt) << SB_FI_ST) | (word_t'(wdt_evt) << SB_WD_ST);
      // set wins over clear
      sts_d   = (sts_q & ~sts_clr) | sts_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         sts_q <= '0;
      end else begin
         if (ctl_wr_en) ctl_q <= ctl_wr_data;
         sts_q <= sts_d;
      end
   end
endmodule

// File: rtl/tbtap_timer_unit.sv
module tbtap_timer_unit
   import tbtap_pkg::*;
#(
   parameter int unsigned        TB_W     = 64,
   parameter int unsigned        TAP_W    = 6,
   parameter bit                 EXT_MODE = 1'b0,
   parameter logic [4*TAP_W-1:0] FIT_TAPS = {6'd10, 6'd8, 6'd6, 6'd4},
   parameter logic [4*TAP_W-1:0] WDT_TAPS = {6'd13, 6'd11, 6'd9, 6'd7}
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctl_wr_en,
   input  logic [31:0]     ctl_wr_data,
   input  logic            sts_wr_en,
   input  logic [31:0]     sts_wr_data,
   input  logic            dbg_resume,
   output logic [31:0]     ctl_q,
   output logic [31:0]     sts_q,
   output logic [TB_W-1:0] tb_q,
   output logic            fit_irq,
   output logic            wdt_irq
);
   logic [TB_W-1:0] tb_nxt;
   logic            fit_evt, wdt_evt;

   tbtap_timebase #(.TB_W(TB_W)) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .tb_q   (tb_q),
      .tb_nxt (tb_nxt)
   );

   tbtap_tap #(.TB_W(TB_W), .TAP_W(TAP_W), .EXT_MODE(EXT_MODE), .TAPS(FIT_TAPS)) u_fit_tap (
      .per_fld (ctl_q[CB_FI_PER_LSB +: 2]),
      .ext_fld (ctl_q[CB_FI_EXT_LSB +: 4]),
      .tb_q    (tb_q),
      .tb_nxt  (tb_nxt),
      .evt     (fit_evt)
   );

   tbtap_tap #(.TB_W(TB_W), .TAP_W(TAP_W), .EXT_MODE(EXT_MODE), .TAPS(WDT_TAPS)) u_wdt_tap (
      .per_fld (ctl_q[CB_WD_PER_LSB +: 2]),
      .ext_fld (ctl_q[CB_WD_EXT_LSB +: 4]),
      .tb_q    (tb_q),
      .tb_nxt  (tb_nxt),
      .evt     (wdt_evt)
   );

   tbtap_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr_en   (ctl_wr_en),
      .ctl_wr_data (ctl_wr_data),
      .sts_wr_en   (sts_wr_en),
      .sts_wr_data (sts_wr_data),
      .dbg_resume  (dbg_resume),
      .fit_evt     (fit_evt),
      .wdt_evt     (wdt_evt),
      .ctl_q       (ctl_q),
      .sts_q       (sts_q)
   );

   assign fit_irq = sts_q[SB_FI_ST] & ctl_q[CB_FI_IE];
   assign wdt_irq = sts_q[SB_WD_ST] & ctl_q[CB_WD_IE];
endmodule

// File: rtl/tbtap_checker.sv
module tbtap_checker #(
   parameter int unsigned TB_W = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ctl_wr_en,
   input logic [31:0]     ctl_wr_data,
   input logic            sts_wr_en,
   input logic [31:0]     sts_wr_data,
   input logic            dbg_resume,
   input logic [31:0]     ctl_q,
   input logic [31:0]     sts_q,
   input logic [TB_W-1:0] tb_q,
   input logic            fit_irq,
   input logic            wdt_irq,
   input logic            fit_evt,
   input logic            wdt_evt
);
   a_r2_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> tb_q == $past(tb_q) + TB_W'(1));

   a_r3_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr_en |=> ctl_q == $past(ctl_wr_data));

   a_r6_fit_set: assert property (@(posedge clk) disable iff (!rst_n)
      fit_evt |=> sts_q[26]);

   a_r6_wdt_set: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_evt |=> sts_q[30]);

   a_r6_fit_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!fit_evt && !sts_q[26]) |=> !sts_q[26]);

   a_r7_fit_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr_en && sts_wr_data[26] && !fit_evt) |=> !sts_q[26]);

   a_r7_fit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[26] && !(sts_wr_en && sts_wr_data[26])) |=> sts_q[26]);

   a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_resume && !wdt_evt) |=> sts_q[31:28] == 4'd0);

   a_r10_fit_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[23] |-> !fit_irq);

   a_r10_wdt_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_q[30] |-> !wdt_irq);
endmodule

bind tbtap_timer_unit tbtap_checker #(.TB_W(TB_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_wr_en   (ctl_wr_en),
   .ctl_wr_data (ctl_wr_data),
   .sts_wr_en   (sts_wr_en),
   .sts_wr_data (sts_wr_data),
   .dbg_resume  (dbg_resume),
   .ctl_q       (ctl_q),
   .sts_q       (sts_q),
   .tb_q        (tb_q),
   .fit_irq     (fit_irq),
   .wdt_irq     (wdt_irq),
   .fit_evt     (fit_evt),
   .wdt_evt     (wdt_evt)
);

// File: tb/test_tbtap_timer_unit.sv
module test_tbtap_timer_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic        ctl_we = 0, sts_we = 0, dbg = 0;
   logic [31:0] ctl_wd = '0, sts_wd = '0;
   logic [31:0] ctl_q, sts_q;
   logic [63:0] tb_q;
   logic        fit_irq, wdt_irq;

   logic        x_ctl_we = 0, x_sts_we = 0, x_dbg = 0;
   logic [31:0] x_ctl_wd = '0, x_sts_wd = '0;
   logic [31:0] x_ctl_q, x_sts_q;
   logic [63:0] x_tb_q;
   logic        x_fit_irq, x_wdt_irq;

   tbtap_timer_unit i_tbtap_timer_unit (
      .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_we), .ctl_wr_data(ctl_wd),
      .sts_wr_en(sts_we), .sts_wr_data(sts_wd), .dbg_resume(dbg),
      .ctl_q(ctl_q), .sts_q(sts_q), .tb_q(tb_q), .fit_irq(fit_irq), .wdt_irq(wdt_irq));

   tbtap_timer_unit #(.EXT_MODE(1'b1)) i_tbtap_timer_unit_ext (
      .clk(clk), .rst_n(rst_n), .ctl_wr_en(x_ctl_we), .ctl_wr_data(x_ctl_wd),
      .sts_wr_en(x_sts_we), .sts_wr_data(x_sts_wd), .dbg_resume(x_dbg),
      .ctl_q(x_ctl_q), .sts_q(x_sts_q), .tb_q(x_tb_q), .fit_irq(x_fit_irq), .wdt_irq(x_wdt_irq));

   localparam int F_CTL = 0, F_STS = 1, F_TB = 2, F_FIRQ = 3, F_WIRQ = 4,
                  F_XSTS = 5, F_XWIRQ = 6, F_XFIRQ = 7;

   typedef struct {
      int          due;
      int          fld;
      logic [63:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    n_chk = 0, n_fail = 0;
   bit    done = 0;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
      end
   endtask

   function automatic logic [63:0] act_of(int f);
      case (f)
         F_CTL:   return 64'(ctl_q);
         F_STS:   return 64'(sts_q);
         F_TB:    return tb_q;
         F_FIRQ:  return 64'(fit_irq);
         F_WIRQ:  return 64'(wdt_irq);
         F_XSTS:  return 64'(x_sts_q);
         F_XWIRQ: return 64'(x_wdt_irq);
         default: return 64'(x_fit_irq);
      endcase
   endfunction

   // monitor: compare every queued item in its due cycle
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
               chk(q[i].tag, act_of(q[i].fld), q[i].exp);
               q.delete(i);
            end
         end
      end
   end

   task automatic expect_at(int due, int fld, logic [63:0] exp, string tag);
      item_t it;
      it.due = due; it.fld = fld; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   // smallest t > from where bit k of t is set and bit k of t-1 is clear
   function automatic int next_rise(int from, int k);
      int t = from + 1;
      while ((t % (1 << (k + 1))) != (1 << k)) t++;
      return t;
   endfunction

   task automatic step_to(int t);
      while (cyc < t) begin @(negedge clk); #1; end
   endtask

   task automatic wr_ctl(logic [31:0] v);
      ctl_we = 1; ctl_wd = v; @(negedge clk); #1; ctl_we = 0;
   endtask
   task automatic wr_sts(logic [31:0] v);
      sts_we = 1; sts_wd = v; @(negedge clk); #1; sts_we = 0;
   endtask
   task automatic pulse_dbg();
      dbg = 1; @(negedge clk); #1; dbg = 0;
   endtask
   task automatic x_wr_ctl(logic [31:0] v);
      x_ctl_we = 1; x_ctl_wd = v; @(negedge clk); #1; x_ctl_we = 0;
   endtask
   task automatic x_wr_sts(logic [31:0] v);
      x_sts_we = 1; x_sts_wd = v; @(negedge clk); #1; x_sts_we = 0;
   endtask

   localparam logic [31:0] FI = 32'h1 << 26;
   localparam logic [31:0] WI = 32'h1 << 30;

   initial begin : main
      int n, e, f2, w, t0, last;
      logic [31:0] v, v2, xv;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ctl", 64'(ctl_q), 64'd0);
      chk("R1 sts", 64'(sts_q), 64'd0);
      chk("R1 tb", tb_q, 64'd0);
      chk("R1 irq", 64'({fit_irq, wdt_irq}), 64'd0);
      #1 rst_n = 1;

      // R3: control write; fit tap code 0 (bit 4), watchdog code 1 (bit 9), fit enable
      v = (32'd1 << 30) | (32'd0 << 24) | (32'd1 << 23);
      expect_at(cyc + 1, F_CTL, 64'(v), "R3 ctl readback");
      wr_ctl(v);

      // R4/R6: first fixed-interval tick on bit 4
      n = next_rise(cyc, 4);
      expect_at(n - 1, F_STS, 64'd0, "R6 before tick");
      expect_at(n - 1, F_FIRQ, 64'd0, "R10 before tick");
      expect_at(n, F_STS, 64'(FI), "R4 R6 fit tick");
      expect_at(n, F_FIRQ, 64'd1, "R10 fit irq");
      expect_at(n, F_TB, 64'(n), "R2 timebase");
      expect_at(n + 5, F_STS, 64'(FI), "R7 sticky");
      step_to(n + 6);
      expect_at(cyc + 1, F_STS, 64'(FI), "R7 unselected bits unchanged");
      wr_sts(WI);
      expect_at(cyc + 1, F_STS, 64'd0, "R7 w1c");
      wr_sts(FI);

      // R8: clear in the same cycle as the tick
      e = next_rise(cyc, 4);
      step_to(e - 1);
      expect_at(e, F_STS, 64'(FI), "R8 set beats clear");
      expect_at(e + 1, F_STS, 64'(FI), "R8 flag held");
      wr_sts(FI);

      // R10: enable gating
      expect_at(cyc + 1, F_FIRQ, 64'd0, "R10 fit disabled");
      expect_at(cyc + 1, F_STS, 64'(FI), "R10 status kept");
      wr_ctl(32'd1 << 30);
      expect_at(cyc + 1, F_FIRQ, 64'd1, "R10 fit re-enabled");
      wr_ctl((32'd1 << 30) | (32'd1 << 23));

      // R11: switch to tap code 1 (bit 6) while bit 6 is already set (tb 64..127)
      step_to(65);
      v2 = (32'd1 << 30) | (32'd1 << 24) | (32'd1 << 23);
      wr_ctl(v2);
      step_to(67);
      expect_at(68, F_STS, 64'd0, "R7 clear before switch check");
      wr_sts(FI);
      expect_at(100, F_STS, 64'd0, "R11 no tick from switch");
      f2 = next_rise(100, 6);
      expect_at(f2 - 1, F_STS, 64'd0, "R11 before bit6 tick");
      expect_at(f2, F_STS, 64'(FI), "R4 tap code 1 tick");

      // R6/R4: watchdog tick on bit 9, gated off
      w = next_rise(f2, 9);
      expect_at(w - 1, F_STS, 64'(FI), "R6 before wdt tick");
      expect_at(w, F_STS, 64'(FI | WI), "R4 R6 wdt tick");
      expect_at(w, F_WIRQ, 64'd0, "R10 wdt gated");
      step_to(w + 1);
      expect_at(cyc + 1, F_WIRQ, 64'd1, "R10 wdt enabled");
      wr_ctl(v2 | (32'd1 << 27));

      // R9: debug resume
      expect_at(cyc + 1, F_STS, 64'(FI), "R9 resume clears wdt only");
      expect_at(cyc + 1, F_WIRQ, 64'd0, "R9 wdt irq drops");
      pulse_dbg();
      expect_at(cyc + 1, F_STS, 64'd0, "R7 clear all");
      wr_sts(32'hFFFF_FFFF);

      // R5: extended mode; fit = 63-(2|15<<2) = bit 1, wdt = 63-(0|15<<2) = bit 3
      t0 = ((cyc / 16) + 1) * 16;
      step_to(t0);
      xv = (32'd0 << 30) | (32'd15 << 17) | (32'd2 << 24) | (32'd15 << 13)
         | (32'd1 << 27) | (32'd1 << 23);
      expect_at(t0 + 1, F_XSTS, 64'd0, "R5 no early tick");
      expect_at(t0 + 2, F_XSTS, 64'(FI), "R5 fit bit1 tick");
      expect_at(t0 + 2, F_XFIRQ, 64'd1, "R5 R10 ext fit irq");
      expect_at(t0 + 7, F_XWIRQ, 64'd0, "R5 before wdt bit3");
      expect_at(t0 + 8, F_XSTS, 64'(FI | WI), "R5 wdt bit3 tick");
      expect_at(t0 + 8, F_XWIRQ, 64'd1, "R5 ext wdt irq");
      x_wr_ctl(xv);
      step_to(t0 + 10);
      expect_at(t0 + 11, F_XSTS, 64'(WI), "R7 ext clear fit");
      x_wr_sts(FI);

      last = t0 + 11;
      step_to(last + 2);
      if (q.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: %0d items never compared (actual=%0d expected=0)", q.size(), q.size());
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung (actual=timeout expected=finish)");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule